// File: doc/BRIEF.md
# Wait-State Controller for a Word-Wide Static RAM

This block connects a synchronous processor bus to a static RAM that is 32 bits wide and built from four byte-wide banks. It decodes a 32K-word window at the bottom of the word address space. When the address strobe falls inside that window, it runs a fixed sequence on the shared chip select and write enable. It returns an active-low ready to the bus master in the last data-phase clock only. A slow RAM therefore gets one full wait state before the master samples ready.

The master presents an address, the write/read level and the strobe in its address-phase clock. The controller registers its decision on that edge. It holds chip select for the wait state and for the final clock, and drops every control on the edge that ends the final clock. The RAM address is the lower 15 bits of the word address, latched when the cycle is accepted. Write data is split into byte lanes, and read data is reassembled from them. Bank 0 carries the most significant byte.

A strobe outside the window is left alone. The controller stays idle so that another responder can claim that cycle.

Top module: `sram_wait_ctrl`

## Requirements
- R1: While rst_ni is low, and at the first sample after it rises, cs_no, we_no and rdy_no are all high.
- R2: A strobe (ads_ni low) is accepted only when the word address addr_i is below 32768. For an address of 32768 or above, cs_no, we_no and rdy_no stay high for the whole cycle.
- R3: After an accepted strobe, cs_no is low from the first clock after the strobe clock through the second clock after it, and high again in the third.
- R4: rdy_no is low only in the second clock after the strobe clock. This makes a read three clocks long including the address phase, with one wait state. ready is never low in two consecutive clocks.
- R5: If wr_i is 1 in the strobe clock, we_no is low in exactly the clocks where cs_no is low. If wr_i is 0, we_no stays high.
- R6: The edge that ends the ready clock drives cs_no, we_no and rdy_no high together. A strobe presented in the very next clock is accepted (back-to-back cycles).
- R7: sram_addr_o equals bits 14:0 of the address sampled in the strobe clock, and it holds that value while cs_no is low, even if addr_i changes.
- R8: bank_wdata_o[k] carries wdata_i bits (31-8k) down to (24-8k), so bank 0 gets bits 31:24 and bank 3 gets bits 7:0. rdata_o places bank_rdata_i[k] in those same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Word address from the bus master |
| ads_ni | input | 1 | Address strobe, active low |
| wr_i | input | 1 | 1 for write, 0 for read, sampled with the strobe |
| wdata_i | input | 32 | Write data from the bus |
| rdata_o | output | 32 | Read data assembled from the banks |
| cs_no | output | 1 | Chip select to all banks, active low |
| we_no | output | 1 | Write enable to all banks, active low |
| rdy_no | output | 1 | Ready to the bus master, active low |
| sram_addr_o | output | 15 | Word address to all banks |
| bank_wdata_o | output | 4x8 | Write data per bank, bank 0 most significant |
| bank_rdata_i | input | 4x8 | Read data per bank |

## Verification
The assertions cover the ordering rules that hold on every clock:
- ready implies chip select;
- write enable implies chip select;
- ready lasts one clock and is followed by a full release;
- chip select falls only after an in-window strobe;
- ready falls only after a wait-state clock.

The exact clock in which each output changes, the address latching and the byte-lane placement are shown only by the bench. It sweeps word addresses across and beyond the window boundary, alternates reads and writes, runs the cycles back-to-back, and changes addr_i during the data phase.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LAST = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode #(
  parameter int ADDR_W    = 32,
  parameter int WIN_WORDS = 32768
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(WIN_WORDS);

  assign hit_o = ({1'b0, addr_i} < LIMIT);
endmodule

// File: rtl/sram_wait_fsm.sv
module sram_wait_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WAIT_STATES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wr_i,
  output logic accept_o,
  output logic cs_no,
  output logic we_no,
  output logic rdy_no
);
  localparam int CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_STATES - 1);

  ctrl_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic wr_q, wr_d;
  logic cs_q, we_q, rdy_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign wr_d     = accept_o ? wr_i : wr_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_WAIT;
        cnt_d   = '0;
      end
      ST_WAIT: begin
        if (cnt_q == CNT_LAST) state_d = ST_LAST;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_LAST: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // outputs registered from next state: no decode glitches toward the RAM
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      cs_q    <= 1'b1;
      we_q    <= 1'b1;
      rdy_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      cs_q    <= (state_d == ST_IDLE);
      we_q    <= !((state_d != ST_IDLE) && wr_d);
      rdy_q   <= (state_d != ST_LAST);
    end
  end

  assign cs_no  = cs_q;
  assign we_no  = we_q;
  assign rdy_no = rdy_q;
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0]       wdata_i,
  input  logic [LANES-1:0][LANE_W-1:0]  bank_rdata_i,
  output logic [LANES-1:0][LANE_W-1:0]  bank_wdata_o,
  output logic [LANES*LANE_W-1:0]       rdata_o
);
  localparam int DATA_W = LANES * LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // bank 0 owns the most significant byte
    assign bank_wdata_o[g] = wdata_i[DATA_W-1-g*LANE_W -: LANE_W];
    assign rdata_o[DATA_W-1-g*LANE_W -: LANE_W] = bank_rdata_i[g];
  end
endmodule

// File: rtl/sram_wait_ctrl.sv
module sram_wait_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int WIN_WORDS   = 32768,
  parameter int WAIT_STATES = 1,
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  localparam int RAM_AW     = $clog2(WIN_WORDS),
  localparam int DATA_W     = LANES * LANE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          ads_ni,
  input  logic                          wr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          cs_no,
  output logic                          we_no,
  output logic                          rdy_no,
  output logic [RAM_AW-1:0]             sram_addr_o,
  output logic [LANES-1:0][LANE_W-1:0]  bank_wdata_o,
  input  logic [LANES-1:0][LANE_W-1:0]  bank_rdata_i
);
  logic hit, accept;
  logic [RAM_AW-1:0] addr_q;

  sram_addr_decode #(.ADDR_W(ADDR_W), .WIN_WORDS(WIN_WORDS)) dec_i (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  sram_wait_fsm #(.WAIT_STATES(WAIT_STATES)) fsm_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (!ads_ni && hit),
    .wr_i     (wr_i),
    .accept_o (accept),
    .cs_no    (cs_no),
    .we_no    (we_no),
    .rdy_no   (rdy_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= addr_i[RAM_AW-1:0];
  end
  assign sram_addr_o = addr_q;

  sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) lane_i (
    .wdata_i      (wdata_i),
    .bank_rdata_i (bank_rdata_i),
    .bank_wdata_o (bank_wdata_o),
    .rdata_o      (rdata_o)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W    = 32,
  parameter int WIN_WORDS = 32768
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ads_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cs_no,
  input logic              we_no,
  input logic              rdy_no
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(WIN_WORDS);
  logic in_win;
  assign in_win = ({1'b0, addr_i} < LIMIT);

  assert_rdy_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |-> !cs_no);
  assert_we_needs_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cs_no);
  assert_rdy_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |=> rdy_no);
  assert_release_after_rdy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |=> (cs_no && we_no));
  assert_cs_from_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(!ads_ni && in_win));
  assert_rdy_after_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> $past(!cs_no));
endmodule

bind sram_wait_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .WIN_WORDS(WIN_WORDS)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ads_ni (ads_ni),
  .addr_i (addr_i),
  .cs_no  (cs_no),
  .we_no  (we_no),
  .rdy_no (rdy_no)
);

// File: tb/sram_wait_ctrl_tb.sv
module sram_wait_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic        ads_ni = 1'b1;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        cs_no, we_no, rdy_no;
  logic [14:0] sram_addr_o;
  logic [3:0][7:0] bank_wdata_o;
  logic [3:0][7:0] bank_rdata_i = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sram_wait_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .ads_ni(ads_ni), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cs_no(cs_no), .we_no(we_no),
    .rdy_no(rdy_no), .sram_addr_o(sram_addr_o), .bank_wdata_o(bank_wdata_o),
    .bank_rdata_i(bank_rdata_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_ctl(input string req, input bit ecs, input bit ewe, input bit erdy);
    check({req, " cs_no"},  32'(cs_no),  32'(ecs));
    check({req, " we_no"},  32'(we_no),  32'(ewe));
    check({req, " rdy_no"}, 32'(rdy_no), 32'(erdy));
  endtask

  task automatic check_lanes(input logic [31:0] wd, input logic [3:0][7:0] rb);
    logic [31:0] exp_r = '0;
    for (int k = 0; k < 4; k++) begin
      check("R8 bank write lane", 32'(bank_wdata_o[k]), (wd >> (24 - 8*k)) & 32'hFF);
      exp_r = exp_r | (32'(rb[k]) << (24 - 8*k));
    end
    check("R8 read assembly", rdata_o, exp_r);
  endtask

  // called at a negedge while idle; returns at the negedge of the release clock
  task automatic bus_cycle(input logic [31:0] a, input bit w, input logic [31:0] wd,
                           input logic [3:0][7:0] rb);
    bit hit = (a < 32'd32768);
    ads_ni = 1'b0; addr_i = a; wr_i = w; wdata_i = wd; bank_rdata_i = rb;
    @(negedge clk);
    ads_ni = 1'b1; addr_i = ~a; wr_i = ~w;
    if (hit) begin
      check_ctl("R3 R5 wait clock", 1'b0, !w, 1'b1);
      check("R7 latched address", 32'(sram_addr_o), a & 32'h7FFF);
    end else begin
      check_ctl("R2 outside window", 1'b1, 1'b1, 1'b1);
    end
    @(negedge clk);
    if (hit) begin
      check_ctl("R4 R5 ready clock", 1'b0, !w, 1'b0);
      check("R7 address held", 32'(sram_addr_o), a & 32'h7FFF);
    end else begin
      check_ctl("R2 outside window", 1'b1, 1'b1, 1'b1);
    end
    check_lanes(wd, rb);
    @(negedge clk);
    check_ctl("R6 release", 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_ctl("R1 in reset", 1'b1, 1'b1, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
    check_ctl("R1 after reset", 1'b1, 1'b1, 1'b1);
    // window edges
    bus_cycle(32'd0,          1'b0, 32'hA1B2C3D4, {8'h11, 8'h22, 8'h33, 8'h44});
    bus_cycle(32'd32767,      1'b1, 32'h0F1E2D3C, {8'h55, 8'h66, 8'h77, 8'h88});
    bus_cycle(32'd32768,      1'b1, 32'hDEADBEEF, {8'h99, 8'hAA, 8'hBB, 8'hCC});
    bus_cycle(32'h8000_0000,  1'b0, 32'h12345678, {8'hDD, 8'hEE, 8'hFF, 8'h01});
    bus_cycle(32'hFFFF_FFFF,  1'b1, 32'h87654321, {8'h02, 8'h03, 8'h04, 8'h05});
    bus_cycle(32'h0000_8000 + 32'd5, 1'b0, 32'h0, {8'h0, 8'h0, 8'h0, 8'h0});
    // sweep across the boundary, alternating read and write, back-to-back
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a  = 32'(i) * 32'd1100 + 32'(i % 7);
      logic [31:0] wd = 32'(i) * 32'h01010101 ^ 32'h5A3C_96F0;
      logic [3:0][7:0] rb;
      for (int k = 0; k < 4; k++) rb[k] = 8'(i * 17 + k * 61);
      bus_cycle(a, i[0], wd, rb);
    end
    // idle gap, strobe held high: nothing moves
    repeat (3) begin
      @(negedge clk);
      check_ctl("R2 no strobe", 1'b1, 1'b1, 1'b1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule